// File: doc/BRIEF.md
# Flash Erase and Program Gate Registers

This block is a small special-function-register bank on an 8-bit core's register bus. Software uses it to steer flash programming and erasing. It holds four things. The first is a control byte with a program-write-enable, a one-shot mass-erase arm, a sticky security bit and a read-only preboot indicator. The other three are a 7-bit page-address register, a 3-bit bank-select field and an erase-trigger location.

A write of any value to the trigger location asks for an erase. The block decides which erase runs and sends a single-cycle start pulse to the flash controller. Both the mass-erase arm and the page address are used up by a launch, so software has to arm again before the next erase. While the controller is busy, or while a launched erase has not yet reported done, the block ignores further triggers and page-address writes.

The program-write-enable output tells the external data-move path where its writes go. When it is 1 they go to program flash, at the data-pointer address. When it is 0 they go to data RAM.

Top module: `flash_sfr_ctrl`

## Requirements
- R1: After reset, the page address, the bank field, the program-write-enable, the mass-erase arm and the security bit are all 0, and neither start pulse is asserted.
- R2: Address 0xB7 holds a 7-bit page address (pages 0 to 127). It reads back as {1'b0, page}, and erase_page_o shows its value.
- R3: Address 0xB6 holds a 3-bit bank field in bits [2:0]. Those bits can be read and written, bits [7:3] read as 0, and bank_o shows the field.
- R4: Control register 0xB2, bit 0, is program-write-enable, readable and writable, and it drives prog_wr_en_o (1 = data-move writes go to program flash, 0 = to data RAM).
- R5: Control bit 1 is the mass-erase arm. A write sets or clears it, it always reads as 0, and a mass-erase launch clears it.
- R6: Control bit 6 is the security bit. Writing 1 sets it, writing 0 has no effect, and only reset clears it. secure_o shows its value.
- R7: Control bit 7 reads back preboot_i, and writes to it have no effect.
- R8: If the arm is set, a write to the trigger address 0x94 gives a one-cycle mass_erase_o pulse in the following cycle. This takes priority over a page erase.
- R9: If the arm is clear and the page address was written after the last page-erase launch, a trigger gives a one-cycle page_erase_o pulse in the following cycle. A later trigger with no new page-address write does nothing.
- R10: A trigger with no arm set and no fresh page address produces no pulse.
- R11: A trigger or page-address write is ignored in any cycle where fl_busy_i is high, or where a launched erase has not yet seen fl_done_i.
- R12: Reads of the trigger address and of unmapped addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sfr_wr_i | input | 1 | Register write strobe |
| sfr_addr_i | input | 8 | Register address |
| sfr_wdata_i | input | 8 | Write data |
| sfr_rdata_o | output | 8 | Read data for sfr_addr_i (combinational) |
| preboot_i | input | 1 | Preboot sequence active |
| fl_busy_i | input | 1 | Flash controller busy |
| fl_done_i | input | 1 | Flash controller finished an erase |
| mass_erase_o | output | 1 | Mass-erase start pulse |
| page_erase_o | output | 1 | Page-erase start pulse |
| erase_page_o | output | 7 | Page to erase |
| bank_o | output | 3 | Bank select |
| prog_wr_en_o | output | 1 | Data-move writes go to program flash |
| secure_o | output | 1 | Security lock |

## Verification
Two things can meet in the same trigger cycle: a pending mass-erase arm and a fresh page address. The bench sets both and then triggers. It expects only the mass pulse, and it expects the page address to stay fresh so that the next trigger, once the erase is done, launches the page erase. The other case is a trigger in the cycle right after a launch, before the modelled controller raises busy. The bench expects that trigger to be dropped. Each cycle is compared with a behavioural model.

// File: rtl/flash_sfr_pkg.sv
package flash_sfr_pkg;
  localparam int unsigned SFR_AW = 8;
  localparam int unsigned SFR_DW = 8;

  localparam logic [SFR_AW-1:0] ADDR_ERASE = 8'h94;
  localparam logic [SFR_AW-1:0] ADDR_CTRL  = 8'hB2;
  localparam logic [SFR_AW-1:0] ADDR_BANK  = 8'hB6;
  localparam logic [SFR_AW-1:0] ADDR_PAGE  = 8'hB7;

  localparam int unsigned BIT_PWE  = 0;
  localparam int unsigned BIT_MEEN = 1;
  localparam int unsigned BIT_SEC  = 6;
  localparam int unsigned BIT_PRE  = 7;

  typedef struct packed {
    logic secure;
    logic meen;
    logic pwe;
  } ctrl_t;
endpackage

// File: rtl/flash_sfr_regs.sv
module flash_sfr_regs
  import flash_sfr_pkg::*;
#(
  parameter int unsigned PAGE_W = 7,
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SFR_AW-1:0] addr_i,
  input  logic [SFR_DW-1:0] wdata_i,
  input  logic              blocked_i,
  input  logic              preboot_i,
  input  logic              take_mass_i,
  input  logic              take_page_i,
  output logic [SFR_DW-1:0] rdata_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [BANK_W-1:0] bank_o,
  output ctrl_t             ctrl_o,
  output logic              fresh_o
);
  localparam int unsigned PAGE_PAD = SFR_DW - PAGE_W;
  localparam int unsigned BANK_PAD = SFR_DW - BANK_W;

  logic wr_ctrl, wr_bank, wr_page;
  logic unused_wdata;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_bank = wr_i && (addr_i == ADDR_BANK);
  assign wr_page = wr_i && (addr_i == ADDR_PAGE) && !blocked_i;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o  <= '0;
      fresh_o <= 1'b0;
    end else if (wr_page) begin
      page_o  <= wdata_i[PAGE_W-1:0];
      fresh_o <= 1'b1;
    end else if (take_page_i) begin
      fresh_o <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bank_o <= '0;
    else if (wr_bank) bank_o <= wdata_i[BANK_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_o.pwe <= wdata_i[BIT_PWE];
        ctrl_o.meen <= wdata_i[BIT_MEEN];
        // set-only lock
        if (wdata_i[BIT_SEC]) ctrl_o.secure <= 1'b1;
      end else if (take_mass_i) begin
        ctrl_o.meen <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_PAGE: rdata_o = {{PAGE_PAD{1'b0}}, page_o};
      ADDR_BANK: rdata_o = {{BANK_PAD{1'b0}}, bank_o};
      ADDR_CTRL: begin
        rdata_o[BIT_PWE] = ctrl_o.pwe;
        rdata_o[BIT_SEC] = ctrl_o.secure;
        rdata_o[BIT_PRE] = preboot_i;
      end
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/flash_erase_launch.sv
module flash_erase_launch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic meen_i,
  input  logic fresh_i,
  input  logic busy_i,
  input  logic done_i,
  output logic blocked_o,
  output logic take_mass_o,
  output logic take_page_o,
  output logic mass_o,
  output logic page_o
);
  logic inflight_q;
  logic accept;

  assign blocked_o   = busy_i | inflight_q;
  assign accept      = trig_i & ~blocked_o;
  // mass erase outranks page erase
  assign take_mass_o = accept & meen_i;
  assign take_page_o = accept & ~meen_i & fresh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mass_o     <= 1'b0;
      page_o     <= 1'b0;
      inflight_q <= 1'b0;
    end else begin
      mass_o <= take_mass_o;
      page_o <= take_page_o;
      if (take_mass_o || take_page_o) inflight_q <= 1'b1;
      else if (done_i) inflight_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_sfr_ctrl.sv
module flash_sfr_ctrl
  import flash_sfr_pkg::*;
#(
  parameter int unsigned PAGE_W = 7,
  parameter int unsigned BANK_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sfr_wr_i,
  input  logic [SFR_AW-1:0] sfr_addr_i,
  input  logic [SFR_DW-1:0] sfr_wdata_i,
  output logic [SFR_DW-1:0] sfr_rdata_o,
  input  logic              preboot_i,
  input  logic              fl_busy_i,
  input  logic              fl_done_i,
  output logic              mass_erase_o,
  output logic              page_erase_o,
  output logic [PAGE_W-1:0] erase_page_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              prog_wr_en_o,
  output logic              secure_o
);
  ctrl_t ctrl;
  logic  blocked, take_mass, take_page, fresh, trig;

  assign trig = sfr_wr_i && (sfr_addr_i == ADDR_ERASE);

  flash_sfr_regs #(.PAGE_W(PAGE_W), .BANK_W(BANK_W)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (sfr_wr_i),
    .addr_i      (sfr_addr_i),
    .wdata_i     (sfr_wdata_i),
    .blocked_i   (blocked),
    .preboot_i   (preboot_i),
    .take_mass_i (take_mass),
    .take_page_i (take_page),
    .rdata_o     (sfr_rdata_o),
    .page_o      (erase_page_o),
    .bank_o      (bank_o),
    .ctrl_o      (ctrl),
    .fresh_o     (fresh)
  );

  flash_erase_launch u_launch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .meen_i      (ctrl.meen),
    .fresh_i     (fresh),
    .busy_i      (fl_busy_i),
    .done_i      (fl_done_i),
    .blocked_o   (blocked),
    .take_mass_o (take_mass),
    .take_page_o (take_page),
    .mass_o      (mass_erase_o),
    .page_o      (page_erase_o)
  );

  assign prog_wr_en_o = ctrl.pwe;
  assign secure_o     = ctrl.secure;
endmodule

// File: rtl/flash_sfr_ctrl_chk.sv
module flash_sfr_ctrl_chk
  import flash_sfr_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sfr_wr_i,
  input logic [SFR_AW-1:0] sfr_addr_i,
  input logic [SFR_DW-1:0] sfr_wdata_i,
  input logic              fl_busy_i,
  input logic              mass_erase_o,
  input logic              page_erase_o,
  input logic              secure_o,
  input logic              prog_wr_en_o
);
  // R8 R9: at most one start pulse
  p_one_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mass_erase_o, page_erase_o}));

  p_mass_needs_trig_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mass_erase_o |-> $past(sfr_wr_i && sfr_addr_i == ADDR_ERASE && !fl_busy_i));

  p_page_needs_trig_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    page_erase_o |-> $past(sfr_wr_i && sfr_addr_i == ADDR_ERASE && !fl_busy_i));

  p_pulse_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mass_erase_o || page_erase_o) |=> !(mass_erase_o || page_erase_o));

  p_secure_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(secure_o));

  p_pwe_follows_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sfr_wr_i && sfr_addr_i == ADDR_CTRL) |=> (prog_wr_en_o == $past(sfr_wdata_i[BIT_PWE])));
endmodule

bind flash_sfr_ctrl flash_sfr_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .sfr_wr_i     (sfr_wr_i),
  .sfr_addr_i   (sfr_addr_i),
  .sfr_wdata_i  (sfr_wdata_i),
  .fl_busy_i    (fl_busy_i),
  .mass_erase_o (mass_erase_o),
  .page_erase_o (page_erase_o),
  .secure_o     (secure_o),
  .prog_wr_en_o (prog_wr_en_o)
);

// File: tb/flash_sfr_ctrl_test.sv
module flash_sfr_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       preboot = 1'b1;
  logic       ctl_busy = 1'b0, force_busy = 1'b0, fl_done = 1'b0;
  logic       fl_busy;
  logic       mass_p, page_p, pwe, sec;
  logic [6:0] epage;
  logic [2:0] bank;

  int checks = 0, fails = 0;
  int ctl_cnt = 0;
  int mass_seen = 0, page_seen = 0;

  // reference model state
  bit       m_pwe, m_meen, m_sec, m_fresh, m_infl, m_mass, m_page;
  bit [6:0] m_page_addr;
  bit [2:0] m_bank;

  assign fl_busy = ctl_busy | force_busy;
  always #(CLK_PERIOD/2) clk = ~clk;

  flash_sfr_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sfr_wr_i(wr), .sfr_addr_i(addr),
    .sfr_wdata_i(wdata), .sfr_rdata_o(rdata), .preboot_i(preboot),
    .fl_busy_i(fl_busy), .fl_done_i(fl_done), .mass_erase_o(mass_p),
    .page_erase_o(page_p), .erase_page_o(epage), .bank_o(bank),
    .prog_wr_en_o(pwe), .secure_o(sec)
  );

  // flash controller stand-in: busy for a few cycles after a start pulse
  always @(posedge clk) begin
    if (mass_p || page_p) begin
      ctl_cnt  <= 3;
      ctl_busy <= 1'b1;
      fl_done  <= 1'b0;
    end else if (ctl_cnt > 0) begin
      ctl_cnt <= ctl_cnt - 1;
      if (ctl_cnt == 1) begin
        ctl_busy <= 1'b0;
        fl_done  <= 1'b1;
      end
    end else begin
      fl_done <= 1'b0;
    end
    mass_seen <= mass_seen + int'(mass_p);
    page_seen <= page_seen + int'(page_p);
  end

  // behavioural model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pwe <= 0; m_meen <= 0; m_sec <= 0; m_fresh <= 0; m_infl <= 0;
      m_mass <= 0; m_page <= 0; m_page_addr <= 0; m_bank <= 0;
    end else begin
      bit stall, go_mass, go_page;
      stall   = fl_busy || m_infl;
      go_mass = wr && addr == 8'h94 && !stall && m_meen;
      go_page = wr && addr == 8'h94 && !stall && !m_meen && m_fresh;
      m_mass <= go_mass;
      m_page <= go_page;
      if (go_mass || go_page) m_infl <= 1;
      else if (fl_done) m_infl <= 0;
      if (wr && addr == 8'hB7 && !stall) begin
        m_page_addr <= wdata[6:0];
        m_fresh <= 1;
      end else if (go_page) m_fresh <= 0;
      if (wr && addr == 8'hB6) m_bank <= wdata[2:0];
      if (wr && addr == 8'hB2) begin
        m_pwe  <= wdata[0];
        m_meen <= wdata[1];
        if (wdata[6]) m_sec <= 1;
      end else if (go_mass) m_meen <= 0;
    end
  end

  function automatic logic [7:0] model_rd(logic [7:0] a);
    case (a)
      8'hB7:   return {1'b0, m_page_addr};
      8'hB6:   return {5'b0, m_bank};
      8'hB2:   return {preboot, m_sec, 4'b0, 1'b0, m_pwe};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the clock edge
  always @(negedge clk) if (rst_n) begin
    check("R8 mass pulse", 32'(mass_p), 32'(m_mass));
    check("R9 page pulse", 32'(page_p), 32'(m_page));
    check("R2 erase page", 32'(epage), 32'(m_page_addr));
    check("R3 bank", 32'(bank), 32'(m_bank));
    check("R4 pwe", 32'(pwe), 32'(m_pwe));
    check("R6 secure", 32'(sec), 32'(m_sec));
    check("R12 rdata", 32'(rdata), 32'(model_rd(addr)));
  end

  task automatic sfr_write(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 8'h00; wdata = 8'h00;
  endtask

  task automatic sfr_read(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    addr = a;
    #1 check(req, 32'(rdata), 32'(exp));
    @(negedge clk);
    addr = 8'h00;
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int mb, pb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 page", 32'(epage), 0);
    check("R1 bank", 32'(bank), 0);
    check("R1 pwe", 32'(pwe), 0);
    check("R1 secure", 32'(sec), 0);
    check("R1 pulses", 32'({mass_p, page_p}), 0);
    sfr_read(8'hB2, 8'h80, "R1 R7 ctrl read with preboot");

    // R3 bank field
    sfr_write(8'hB6, 8'h05);
    sfr_read(8'hB6, 8'h05, "R3 bank readback");
    sfr_write(8'hB6, 8'hFF);
    sfr_read(8'hB6, 8'h07, "R3 bank upper bits zero");

    // R10 trigger with nothing armed
    mb = mass_seen; pb = page_seen;
    sfr_write(8'h94, 8'h00);
    settle();
    check("R10 no launch", 32'(mass_seen + page_seen), 32'(mb + pb));

    // R2 R9 page erase, then repeat without rewrite
    sfr_write(8'hB7, 8'hA5);
    sfr_read(8'hB7, 8'h25, "R2 page readback");
    pb = page_seen;
    sfr_write(8'h94, 8'h01);
    settle();
    check("R9 page launched", 32'(page_seen), 32'(pb + 1));
    check("R9 page value", 32'(epage), 32'h25);
    sfr_write(8'h94, 8'h01);
    settle();
    check("R9 stale page ignored", 32'(page_seen), 32'(pb + 1));

    // R5 R8 mass erase, arm reads 0, consumed
    sfr_write(8'hB2, 8'h02);
    sfr_read(8'hB2, 8'h80, "R5 arm reads zero");
    mb = mass_seen;
    sfr_write(8'h94, 8'h00);
    settle();
    check("R8 mass launched", 32'(mass_seen), 32'(mb + 1));
    sfr_write(8'h94, 8'h00);
    settle();
    check("R5 arm consumed", 32'(mass_seen), 32'(mb + 1));

    // R8 priority: arm and fresh page together
    sfr_write(8'hB7, 8'h11);
    sfr_write(8'hB2, 8'h02);
    mb = mass_seen; pb = page_seen;
    sfr_write(8'h94, 8'h00);
    // R11 trigger in the cycle after launch, before busy rises
    wr = 1'b1; addr = 8'h94;
    @(negedge clk);
    wr = 1'b0; addr = 8'h00;
    settle();
    check("R8 mass wins", 32'(mass_seen), 32'(mb + 1));
    check("R11 trigger during launch ignored", 32'(page_seen), 32'(pb));
    sfr_write(8'h94, 8'h00);
    settle();
    check("R9 page still fresh after mass", 32'(page_seen), 32'(pb + 1));

    // R11 busy blocks page write and trigger
    force_busy = 1'b1;
    sfr_write(8'hB7, 8'h33);
    sfr_write(8'h94, 8'h00);
    settle();
    check("R11 page write blocked", 32'(epage), 32'h11);
    check("R11 trigger blocked", 32'(page_seen), 32'(pb + 1));
    force_busy = 1'b0;
    sfr_write(8'h94, 8'h00);
    settle();
    check("R11 no fresh page after blocked write", 32'(page_seen), 32'(pb + 1));

    // R4 R6 R7 control bits
    sfr_write(8'hB2, 8'h41);
    sfr_read(8'hB2, 8'hC1, "R4 R6 ctrl set");
    sfr_write(8'hB2, 8'h00);
    check("R6 secure sticky", 32'(sec), 1);
    check("R4 pwe cleared", 32'(pwe), 0);
    preboot = 1'b0;
    sfr_write(8'hB2, 8'h80);
    sfr_read(8'hB2, 8'h40, "R7 preboot read-only");

    // R12 reads
    sfr_read(8'h94, 8'h00, "R12 trigger reads zero");
    sfr_read(8'h3C, 8'h00, "R12 unmapped reads zero");

    // R6 reset clears secure
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 R1 secure cleared by reset", 32'(sec), 0);
    check("R1 bank after reset", 32'(bank), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule